// File: doc/BRIEF.md
# Trap Entry and Delegation Unit

This unit performs the architectural state update of a hart in the clock edge where an exception or interrupt is accepted. The execution pipeline presents the cause word, the PC of the trapping instruction, an optional faulting address with a valid flag, and the two delegation masks, and pulses a take strobe. In that same edge the unit decides whether the supervisor or the machine level handles the trap. It then loads the new PC from that level's trap vector, records cause, return PC and faulting address in that level's registers, pushes the status stack, switches privilege, and drops any load reservation.

Besides the trap path, the unit holds the two trap vector registers, the status word, the current privilege and the reservation flag. The surrounding core writes these through simple write strobes. Return-from-trap and vectored dispatch live elsewhere.

Top module: `trap_entry_unit`

## Requirements
- R1: After reset, the privilege is machine (encoding 3; user is 0, supervisor is 1), the PC equals the RESET_VEC parameter, the reservation is clear, and the status word, all cause, return-PC, faulting-address and vector registers are zero.
- R2: When cause bit XLEN-1 is 1, the interrupt mask is consulted at the index formed by the cause with that bit cleared. Otherwise the exception mask is consulted at the index equal to the cause.
- R3: A trap goes to the supervisor only when the current privilege is user or supervisor, the index is below XLEN and the consulted mask bit is 1. Every other trap, including every trap taken in machine mode, goes to the machine level.
- R4: A supervisor trap loads the PC from the supervisor vector and writes the full cause word and the return PC to the supervisor registers. The supervisor faulting address is written only when the address-valid flag is 1. The machine cause, return-PC and faulting-address registers keep their values.
- R5: A machine trap does the same with the machine vector, cause, return-PC and faulting-address registers, leaving the supervisor ones unchanged.
- R6: On a supervisor trap, status bit 5 takes the status bit whose index equals the current privilege. Status bit 8 takes bit 0 of the privilege, status bit 1 is cleared, the privilege becomes supervisor, and all other status bits hold.
- R7: On a machine trap, status bit 7 takes the status bit whose index equals the current privilege. Status bits 12:11 take the privilege, status bit 3 is cleared, the privilege becomes machine, and all other status bits hold.
- R8: A reservation set request makes the reservation valid. Any trap clears it, and this takes precedence over a set request in the same cycle.
- R9: A write to either vector register stores the write data with bits 1:0 forced to zero. A trap in the same cycle uses the vector value held before the write.
- R10: A status write updates only bits 0, 1, 3, 5, 7, 8, 11 and 12. A privilege write of 0, 1 or 3 is accepted and a write of 2 is ignored. Both writes are ignored in a cycle where a trap is taken.
- R11: Without a trap, the PC and all cause, return-PC and faulting-address registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | Trap accepted this cycle |
| cause_i | input | XLEN | Cause word, bit XLEN-1 marks an interrupt |
| epc_i | input | XLEN | PC of the trapping instruction |
| badaddr_i | input | XLEN | Faulting address |
| badaddr_vld_i | input | 1 | Faulting address is meaningful |
| exc_deleg_i | input | XLEN | Exception delegation mask |
| irq_deleg_i | input | XLEN | Interrupt delegation mask |
| status_wr_i | input | 1 | Status write strobe |
| status_wdata_i | input | 13 | Status write data |
| priv_wr_i | input | 1 | Privilege write strobe |
| priv_wdata_i | input | 2 | Privilege write data |
| mtvec_wr_i | input | 1 | Machine vector write strobe |
| stvec_wr_i | input | 1 | Supervisor vector write strobe |
| tvec_wdata_i | input | XLEN | Vector write data |
| resv_set_i | input | 1 | Load reservation set request |
| pc_o | output | XLEN | Program counter |
| priv_o | output | 2 | Current privilege |
| status_o | output | 13 | Status word |
| mcause_o | output | XLEN | Machine cause |
| mepc_o | output | XLEN | Machine return PC |
| mbadaddr_o | output | XLEN | Machine faulting address |
| scause_o | output | XLEN | Supervisor cause |
| sepc_o | output | XLEN | Supervisor return PC |
| sbadaddr_o | output | XLEN | Supervisor faulting address |
| mtvec_o | output | XLEN | Machine trap vector |
| stvec_o | output | XLEN | Supervisor trap vector |
| resv_valid_o | output | 1 | Load reservation held |

## Verification
Every piece of state is a port, so a wrong routing decision shows at the edge right after the strobe. It appears as the PC taken from the other vector, a privilege of 1 instead of 3 (or the reverse), and the cause landing in the wrong level's register. A wrong status stack shows up in the same cycle as a wrong status bit. A missed hold shows up one cycle after any idle cycle as a drifting PC or cause register. The bench compares every output in every cycle against its own model, so no error stays hidden for more than one clock.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int STW = 13;

  localparam int B_UIE  = 0;
  localparam int B_SIE  = 1;
  localparam int B_MIE  = 3;
  localparam int B_SPIE = 5;
  localparam int B_MPIE = 7;
  localparam int B_SPP  = 8;
  localparam int B_MPP  = 11;

  localparam logic [STW-1:0] STATUS_WMASK = 13'h19AB;

  typedef enum logic [1:0] {
    PRIV_U    = 2'd0,
    PRIV_S    = 2'd1,
    PRIV_RSVD = 2'd2,
    PRIV_M    = 2'd3
  } priv_e;

  // push the supervisor side of the status stack
  function automatic logic [STW-1:0] push_s(logic [STW-1:0] st, logic [1:0] prv);
    logic [STW-1:0] r;
    r         = st;
    r[B_SPIE] = st[prv];
    r[B_SPP]  = prv[0];
    r[B_SIE]  = 1'b0;
    return r;
  endfunction

  // push the machine side of the status stack
  function automatic logic [STW-1:0] push_m(logic [STW-1:0] st, logic [1:0] prv);
    logic [STW-1:0] r;
    r              = st;
    r[B_MPIE]      = st[prv];
    r[B_MPP+1:B_MPP] = prv;
    r[B_MIE]       = 1'b0;
    return r;
  endfunction

  function automatic logic [STW-1:0] masked_write(logic [STW-1:0] st, logic [STW-1:0] wd);
    return (st & ~STATUS_WMASK) | (wd & STATUS_WMASK);
  endfunction
endpackage

// File: rtl/trap_route.sv
module trap_route #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] irq_deleg_i,
  input  logic [1:0]      priv_i,
  output logic            to_s_o,
  output logic            idx_in_range_o,
  output logic            deleg_bit_o
);
  localparam int IDXW = $clog2(XLEN);

  logic            is_irq;
  logic [XLEN-1:0] idx;
  logic [XLEN-1:0] mask;
  logic            low_priv;

  assign is_irq         = cause_i[XLEN-1];
  assign idx            = is_irq ? {1'b0, cause_i[XLEN-2:0]} : cause_i;
  assign mask           = is_irq ? irq_deleg_i : exc_deleg_i;
  assign idx_in_range_o = ~|idx[XLEN-1:IDXW];
  assign deleg_bit_o    = idx_in_range_o & mask[idx[IDXW-1:0]];
  assign low_priv       = (priv_i == trap_pkg::PRIV_U) || (priv_i == trap_pkg::PRIV_S);
  assign to_s_o         = low_priv & deleg_bit_o;
endmodule

// File: rtl/trap_level_regs.sv
module trap_level_regs #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            badaddr_vld_i,
  output logic [XLEN-1:0] cause_q,
  output logic [XLEN-1:0] epc_q,
  output logic [XLEN-1:0] badaddr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause_q   <= '0;
      epc_q     <= '0;
      badaddr_q <= '0;
    end else if (load_i) begin
      cause_q <= cause_i;
      epc_q   <= epc_i;
      if (badaddr_vld_i) badaddr_q <= badaddr_i;
    end
  end
endmodule

// File: rtl/trap_status_unit.sv
module trap_status_unit
  import trap_pkg::*;
(
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take_i,
  input  logic           to_s_i,
  input  logic [1:0]     priv_i,
  input  logic           wr_i,
  input  logic [STW-1:0] wdata_i,
  output logic [STW-1:0] status_q
);
  logic [STW-1:0] status_d;

  always_comb begin
    status_d = status_q;
    if (take_i)    status_d = to_s_i ? push_s(status_q, priv_i) : push_m(status_q, priv_i);
    else if (wr_i) status_d = masked_write(status_q, wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end
endmodule

// File: rtl/trap_entry_unit.sv
module trap_entry_unit
  import trap_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'h0000_1000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] badaddr_i,
  input  logic            badaddr_vld_i,
  input  logic [XLEN-1:0] exc_deleg_i,
  input  logic [XLEN-1:0] irq_deleg_i,
  input  logic            status_wr_i,
  input  logic [12:0]     status_wdata_i,
  input  logic            priv_wr_i,
  input  logic [1:0]      priv_wdata_i,
  input  logic            mtvec_wr_i,
  input  logic            stvec_wr_i,
  input  logic [XLEN-1:0] tvec_wdata_i,
  input  logic            resv_set_i,
  output logic [XLEN-1:0] pc_o,
  output logic [1:0]      priv_o,
  output logic [12:0]     status_o,
  output logic [XLEN-1:0] mcause_o,
  output logic [XLEN-1:0] mepc_o,
  output logic [XLEN-1:0] mbadaddr_o,
  output logic [XLEN-1:0] scause_o,
  output logic [XLEN-1:0] sepc_o,
  output logic [XLEN-1:0] sbadaddr_o,
  output logic [XLEN-1:0] mtvec_o,
  output logic [XLEN-1:0] stvec_o,
  output logic            resv_valid_o
);
  localparam int NLVL = 2;  // index 0 supervisor, 1 machine

  // routing events, visible to the checker
  logic trap_to_s;
  logic trap_to_m;
  logic idx_in_range;
  logic deleg_bit;

  trap_route #(.XLEN(XLEN)) u_route (
    .cause_i        (cause_i),
    .exc_deleg_i    (exc_deleg_i),
    .irq_deleg_i    (irq_deleg_i),
    .priv_i         (priv_o),
    .to_s_o         (trap_to_s),
    .idx_in_range_o (idx_in_range),
    .deleg_bit_o    (deleg_bit)
  );

  assign trap_to_m = take_i & ~trap_to_s;

  logic [NLVL-1:0] lvl_load;
  logic [XLEN-1:0] lvl_cause [NLVL];
  logic [XLEN-1:0] lvl_epc   [NLVL];
  logic [XLEN-1:0] lvl_bad   [NLVL];

  assign lvl_load = {trap_to_m, take_i & trap_to_s};

  for (genvar g = 0; g < NLVL; g++) begin : g_lvl
    trap_level_regs #(.XLEN(XLEN)) u_regs (
      .clk           (clk),
      .rst_n         (rst_n),
      .load_i        (lvl_load[g]),
      .cause_i       (cause_i),
      .epc_i         (epc_i),
      .badaddr_i     (badaddr_i),
      .badaddr_vld_i (badaddr_vld_i),
      .cause_q       (lvl_cause[g]),
      .epc_q         (lvl_epc[g]),
      .badaddr_q     (lvl_bad[g])
    );
  end

  assign scause_o   = lvl_cause[0];
  assign sepc_o     = lvl_epc[0];
  assign sbadaddr_o = lvl_bad[0];
  assign mcause_o   = lvl_cause[1];
  assign mepc_o     = lvl_epc[1];
  assign mbadaddr_o = lvl_bad[1];

  trap_status_unit u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_i   (take_i),
    .to_s_i   (trap_to_s),
    .priv_i   (priv_o),
    .wr_i     (status_wr_i),
    .wdata_i  (status_wdata_i),
    .status_q (status_o)
  );

  logic priv_wr_ok;
  assign priv_wr_ok = priv_wr_i && (priv_wdata_i != PRIV_RSVD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_o         <= RESET_VEC;
      priv_o       <= PRIV_M;
      mtvec_o      <= '0;
      stvec_o      <= '0;
      resv_valid_o <= 1'b0;
    end else begin
      if (take_i) begin
        pc_o   <= trap_to_s ? stvec_o : mtvec_o;
        priv_o <= trap_to_s ? PRIV_S : PRIV_M;
      end else if (priv_wr_ok) begin
        priv_o <= priv_wdata_i;
      end
      if (mtvec_wr_i) mtvec_o <= {tvec_wdata_i[XLEN-1:2], 2'b00};
      if (stvec_wr_i) stvec_o <= {tvec_wdata_i[XLEN-1:2], 2'b00};
      if (take_i)          resv_valid_o <= 1'b0;
      else if (resv_set_i) resv_valid_o <= 1'b1;
    end
  end
endmodule

// File: rtl/trap_entry_chk.sv
module trap_entry_chk #(
  parameter int XLEN = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            take_i,
  input logic [XLEN-1:0] cause_i,
  input logic [XLEN-1:0] epc_i,
  input logic            badaddr_vld_i,
  input logic            mtvec_wr_i,
  input logic [XLEN-1:0] tvec_wdata_i,
  input logic            trap_to_s,
  input logic [XLEN-1:0] pc_o,
  input logic [1:0]      priv_o,
  input logic [12:0]     status_o,
  input logic [XLEN-1:0] mcause_o,
  input logic [XLEN-1:0] scause_o,
  input logic [XLEN-1:0] sepc_o,
  input logic [XLEN-1:0] sbadaddr_o,
  input logic [XLEN-1:0] mtvec_o,
  input logic [XLEN-1:0] stvec_o,
  input logic            resv_valid_o
);
  assert_m_keeps_m_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && priv_o == 2'd3) |=> priv_o == 2'd3);

  assert_s_entry_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && trap_to_s) |=> (pc_o == $past(stvec_o)) && (scause_o == $past(cause_i))
                              && (sepc_o == $past(epc_i)) && $stable(mcause_o));

  assert_s_nobad_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && trap_to_s && !badaddr_vld_i) |=> $stable(sbadaddr_o));

  assert_m_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !trap_to_s) |=> (pc_o == $past(mtvec_o)) && (mcause_o == $past(cause_i))
                               && $stable(scause_o));

  assert_s_stack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && trap_to_s) |=> !status_o[1] && (status_o[8] == $past(priv_o[0])) && priv_o == 2'd1);

  assert_m_stack_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !trap_to_s) |=> !status_o[3] && (status_o[12:11] == $past(priv_o)) && priv_o == 2'd3);

  assert_resv_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> !resv_valid_o);

  assert_tvec_align_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mtvec_wr_i |=> mtvec_o == {$past(tvec_wdata_i[XLEN-1:2]), 2'b00});

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> $stable(pc_o) && $stable(mcause_o) && $stable(scause_o) && $stable(sepc_o));
endmodule

bind trap_entry_unit trap_entry_chk #(.XLEN(XLEN)) u_trap_entry_chk (.*);

// File: tb/test_trap_entry_unit.sv
module test_trap_entry_unit;
  localparam int          XLEN = 32;
  localparam logic [31:0] RV   = 32'h0000_1000;
  localparam logic [12:0] WM   = 13'h19AB;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n;
  logic        take_i, badaddr_vld_i, status_wr_i, priv_wr_i, mtvec_wr_i, stvec_wr_i, resv_set_i;
  logic [31:0] cause_i, epc_i, badaddr_i, exc_deleg_i, irq_deleg_i, tvec_wdata_i;
  logic [12:0] status_wdata_i;
  logic [1:0]  priv_wdata_i;
  logic [31:0] pc_o, mcause_o, mepc_o, mbadaddr_o, scause_o, sepc_o, sbadaddr_o, mtvec_o, stvec_o;
  logic [1:0]  priv_o;
  logic [12:0] status_o;
  logic        resv_valid_o;

  trap_entry_unit #(.XLEN(XLEN), .RESET_VEC(RV)) i_trap_entry_unit (.*);

  int checks = 0;
  int errors = 0;

  logic [31:0] e_pc, e_mc, e_me, e_mb, e_sc, e_se, e_sb, e_mt, e_stv;
  logic [1:0]  e_priv;
  logic [12:0] e_st;
  logic        e_rv;
  string       t_lvl, t_st, t_pc;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // independent routing rule
  function automatic bit b_to_s(logic [31:0] c, logic [31:0] med, logic [31:0] mid, logic [1:0] p);
    logic [31:0] idx;
    logic [31:0] m;
    if (c[31]) begin idx = c & 32'h7FFF_FFFF; m = mid; end
    else       begin idx = c;                 m = med; end
    if (p == 2'd3 || idx >= 32) return 1'b0;
    return m[idx[4:0]];
  endfunction

  task automatic model_next();
    bit ts;
    bit pe;
    t_lvl = "R11"; t_st = "R11"; t_pc = "R11";
    if (take_i) begin
      ts = b_to_s(cause_i, exc_deleg_i, irq_deleg_i, e_priv);
      pe = e_st[e_priv];
      if (ts) begin
        e_pc = e_stv; e_sc = cause_i; e_se = epc_i;
        if (badaddr_vld_i) e_sb = badaddr_i;
        e_st[5] = pe; e_st[8] = e_priv[0]; e_st[1] = 1'b0; e_priv = 2'd1;
        t_lvl = "R4"; t_st = "R6"; t_pc = "R4";
      end else begin
        e_pc = e_mt; e_mc = cause_i; e_me = epc_i;
        if (badaddr_vld_i) e_mb = badaddr_i;
        e_st[7] = pe; e_st[12:11] = e_priv; e_st[3] = 1'b0; e_priv = 2'd3;
        t_lvl = "R5"; t_st = "R7"; t_pc = "R5";
      end
      e_rv = 1'b0;
    end else begin
      if (status_wr_i) begin e_st = (e_st & ~WM) | (status_wdata_i & WM); t_st = "R10"; end
      if (priv_wr_i && priv_wdata_i != 2'd2) e_priv = priv_wdata_i;
      if (resv_set_i) e_rv = 1'b1;
    end
    if (mtvec_wr_i) e_mt  = tvec_wdata_i & 32'hFFFF_FFFC;
    if (stvec_wr_i) e_stv = tvec_wdata_i & 32'hFFFF_FFFC;
  endtask

  task automatic compare(string force_tag);
    string tl, ts, tp;
    tl = (force_tag != "") ? force_tag : t_lvl;
    ts = (force_tag != "") ? force_tag : t_st;
    tp = (force_tag != "") ? force_tag : t_pc;
    chk(tp, "pc", pc_o, e_pc);
    chk(ts, "priv", {30'd0, priv_o}, {30'd0, e_priv});
    chk(ts, "status", {19'd0, status_o}, {19'd0, e_st});
    chk(tl, "mcause", mcause_o, e_mc);
    chk(tl, "mepc", mepc_o, e_me);
    chk(tl, "mbad", mbadaddr_o, e_mb);
    chk(tl, "scause", scause_o, e_sc);
    chk(tl, "sepc", sepc_o, e_se);
    chk(tl, "sbad", sbadaddr_o, e_sb);
    chk((force_tag != "") ? force_tag : "R9", "mtvec", mtvec_o, e_mt);
    chk((force_tag != "") ? force_tag : "R9", "stvec", stvec_o, e_stv);
    chk((force_tag != "") ? force_tag : "R8", "resv", {31'd0, resv_valid_o}, {31'd0, e_rv});
  endtask

  task automatic idle_inputs();
    take_i = 0; cause_i = 0; epc_i = 0; badaddr_i = 0; badaddr_vld_i = 0;
    exc_deleg_i = 0; irq_deleg_i = 0; status_wr_i = 0; status_wdata_i = 0;
    priv_wr_i = 0; priv_wdata_i = 0; mtvec_wr_i = 0; stvec_wr_i = 0;
    tvec_wdata_i = 0; resv_set_i = 0;
  endtask

  task automatic cyc(string tag);
    model_next();
    @(negedge clk);
    compare(tag);
    idle_inputs();
  endtask

  task automatic set_priv(logic [1:0] p);
    priv_wr_i = 1; priv_wdata_i = p;
    cyc("R10");
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    e_pc = RV; e_priv = 2'd3; e_st = '0; e_rv = 0;
    e_mc = 0; e_me = 0; e_mb = 0; e_sc = 0; e_se = 0; e_sb = 0; e_mt = 0; e_stv = 0;
    compare("R1");

    // vectors with unaligned data (R9)
    mtvec_wr_i = 1; tvec_wdata_i = 32'h0000_2003; cyc("R9");
    stvec_wr_i = 1; tvec_wdata_i = 32'h0000_3006; cyc("R9");

    // R2: interrupt bit 5 delegated only in the interrupt mask
    set_priv(2'd1);
    take_i = 1; cause_i = 32'h8000_0005; epc_i = 32'h40; exc_deleg_i = 0; irq_deleg_i = 32'h20;
    cyc("R2");
    // R2: same index as an exception uses the exception mask -> machine
    take_i = 1; cause_i = 32'h0000_0005; epc_i = 32'h44; exc_deleg_i = 0; irq_deleg_i = 32'h20;
    badaddr_i = 32'hDEAD_BEE0; badaddr_vld_i = 1;
    cyc("R2");

    // R3: machine mode never delegates
    take_i = 1; cause_i = 32'd2; exc_deleg_i = '1; irq_deleg_i = '1; cyc("R3");
    // R3: index out of range from user mode -> machine
    set_priv(2'd0);
    take_i = 1; cause_i = 32'd40; exc_deleg_i = '1; irq_deleg_i = '1; cyc("R3");
    set_priv(2'd0);
    take_i = 1; cause_i = 32'h8000_0028; exc_deleg_i = '1; irq_deleg_i = '1; cyc("R3");

    // R9: vector write with a delegated trap in the same cycle uses old vector
    set_priv(2'd1);
    take_i = 1; cause_i = 32'd8; exc_deleg_i = 32'h100; stvec_wr_i = 1; tvec_wdata_i = 32'hFFFF_FFFF;
    cyc("R9");

    // R8: set then set-with-trap
    resv_set_i = 1; cyc("R8");
    resv_set_i = 1; take_i = 1; cause_i = 32'd3; cyc("R8");

    // R10: status write masked, priv write of 2 ignored, writes ignored on trap
    status_wr_i = 1; status_wdata_i = 13'h1FFF; cyc("R10");
    priv_wr_i = 1; priv_wdata_i = 2'd2; cyc("R10");
    status_wr_i = 1; status_wdata_i = 13'h0000; priv_wr_i = 1; priv_wdata_i = 2'd0;
    take_i = 1; cause_i = 32'd1; cyc("R10");

    // randomized traffic
    for (int n = 0; n < 4000; n++) begin
      take_i         = ($urandom % 100) < 40;
      cause_i        = {1'($urandom % 2), 31'($urandom % 40)};
      epc_i          = $urandom;
      badaddr_i      = $urandom;
      badaddr_vld_i  = 1'($urandom % 2);
      exc_deleg_i    = $urandom;
      irq_deleg_i    = $urandom;
      status_wr_i    = ($urandom % 100) < 25;
      status_wdata_i = 13'($urandom);
      priv_wr_i      = ($urandom % 100) < 35;
      priv_wdata_i   = 2'($urandom);
      mtvec_wr_i     = ($urandom % 100) < 10;
      stvec_wr_i     = ($urandom % 100) < 10;
      tvec_wdata_i   = $urandom;
      resv_set_i     = ($urandom % 100) < 30;
      cyc("");
    end
    summary();
  end
endmodule